// File: doc/BRIEF.md
# Configuration Chain Load Self-Test

This block holds one element's serial configuration register and checks it for a stuck cell while it is being filled. Before the real configuration goes in, every element in an array receives the same fixed test stream in parallel. The stream is one bit longer than the register. Its first bit passes through the whole register and ends in the element's data flip-flop. That flip-flop is kept as an outside triple, and only its majority value comes back into this block.

The stream is laid out so that, once it has fully arrived, two things hold. A pair of ones sits at the entry end of the register. The two head positions read 0 and then 1: the last register cell holds 0 and the flip-flop majority holds 1. A cell stuck at 0 or at 1 forces every position downstream of it to that constant as the stream shifts. The head then reads 00 or 11, and the block raises a sticky fault flag. The array's spare mechanism uses that flag to retire the element.

A test session opens with a one-cycle strobe. The block counts the shift cycles that follow. It makes its judgement on the cycle after the counted shift that completes the stream, and judges exactly once per session.

Top module: `cfg_load_selftest`

## Requirements
- R1: After synchronous reset, `cfg_q` is all zeros, `ff_d` is 0 and `fault` is 0.
- R2: On a clock edge with `shift_en` high, `cfg_q` becomes `{cfg_q[CFG_BITS-2:0], ser_in}`. With `shift_en` low, `cfg_q` holds its value. `ff_d` always equals `cfg_q[CFG_BITS-1]`, which is the bit the outside flip-flop triple loads on a shift.
- R3: A clock edge with `test_start` high does three things. It clears `fault`, sets the shift count to zero and opens a session. A shift on that same edge still moves data but is not counted.
- R4: In an open session, the CFG_BITS+1 counted shifts make up the stream. On the edge after the last of them, `fault` is set to 1 if `cfg_q[CFG_BITS-1]` is 1 or `ff_maj` is 0. Otherwise it is set to 0. The session then closes.
- R5: The correct stream is sent first bit to last: a 1, then CFG_BITS-2 zeros, then two ones. It leaves `fault` at 0.
- R6: A stream whose head resolves to 00 (leading bit 0, as a downstream stuck-at-0 would leave it) sets `fault`.
- R7: A stream whose head resolves to 11 (the second bit sent is 1, or the whole stream is ones, as a stuck-at-1 would leave it) sets `fault`.
- R8: A correct stream with `ff_maj` held at 0 sets `fault`. This is the flip-flop position check.
- R9: Once set, `fault` stays 1 through any further shifting until the next `test_start` or reset.
- R10: Shifting without an open session never changes `fault`, whatever the data.
- R11: Cycles with `shift_en` low inside a session do not advance the count. Gapped streams are judged at the same point in the stream as back-to-back ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_start | input | 1 | One-cycle strobe that opens a self-test session |
| shift_en | input | 1 | Shift the configuration chain by one position |
| ser_in | input | 1 | Serial configuration / test data |
| ff_maj | input | 1 | Majority value of the outside data flip-flop triple |
| ff_d | output | 1 | Chain head bit, loaded by the flip-flop triple on a shift |
| cfg_q | output | CFG_BITS | Parallel contents of the configuration register |
| fault | output | 1 | Sticky stuck-cell verdict of the last session |

## Verification
The bench goes after the exact verdict cycle. If the count is off by one, the verdict lands one cycle early or late and is read from a half-shifted head, and the per-cycle model comparison exposes this. It drives both failing head codes (00 and 11) and a failing flip-flop majority with a clean register. A design that only checked one of the head bits, or ignored the flip-flop, would miss one of these. It also covers:
- streams with idle gaps, which a design counting clock cycles instead of shifts would misjudge;
- a restart strobe in the middle of a stream;
- shifting with no session open, which a design that judges unconditionally would flag;
- extra shifts after a fault, which a non-sticky flag would lose.

// File: rtl/cfgst_pkg.sv
package cfgst_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE  = 1'b0,
    SEQ_COUNT = 1'b1
  } seq_state_t;

  // Healthy head reads 0 in the last register cell and 1 in the flip-flop.
  function automatic logic head_bad(input logic last_cell, input logic ff_bit);
    return last_cell | ~ff_bit;
  endfunction

endpackage

// File: rtl/cfgst_chain.sv
module cfgst_chain #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic d;
    if (i == 0) begin : g_entry
      assign d = ser_in;
    end else begin : g_link
      assign d = q[i-1];
    end
    always_ff @(posedge clk) begin
      if (rst)           q[i] <= 1'b0;
      else if (shift_en) q[i] <= d;
    end
  end

endmodule

// File: rtl/cfgst_seq.sv
module cfgst_seq
  import cfgst_pkg::*;
#(
  parameter int STREAM_LEN = 21
) (
  input  logic clk,
  input  logic rst,
  input  logic test_start,
  input  logic shift_en,
  output logic eval
);

  localparam int CW = $clog2(STREAM_LEN + 2);
  localparam logic [CW-1:0] TGT = CW'(STREAM_LEN);

  seq_state_t    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else if (test_start) begin
      state <= SEQ_COUNT;
      cnt   <= '0;
    end else if (state == SEQ_COUNT) begin
      if (cnt == TGT)    state <= SEQ_IDLE;
      else if (shift_en) cnt   <= cnt + CW'(1);
    end
  end

  assign eval = (state == SEQ_COUNT) && (cnt == TGT) && !test_start;

endmodule

// File: rtl/cfgst_judge.sv
module cfgst_judge
  import cfgst_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic test_start,
  input  logic eval,
  input  logic last_cell,
  input  logic ff_maj,
  output logic fault
);

  always_ff @(posedge clk) begin
    if (rst)             fault <= 1'b0;
    else if (test_start) fault <= 1'b0;
    else if (eval)       fault <= head_bad(last_cell, ff_maj);
  end

endmodule

// File: rtl/cfg_load_selftest.sv
module cfg_load_selftest #(
  parameter int CFG_BITS = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                test_start,
  input  logic                shift_en,
  input  logic                ser_in,
  input  logic                ff_maj,
  output logic                ff_d,
  output logic [CFG_BITS-1:0] cfg_q,
  output logic                fault
);

  localparam int STREAM_LEN = CFG_BITS + 1;

  logic eval;

  cfgst_chain #(.WIDTH(CFG_BITS)) u_chain (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in), .q(cfg_q)
  );

  cfgst_seq #(.STREAM_LEN(STREAM_LEN)) u_seq (
    .clk(clk), .rst(rst), .test_start(test_start), .shift_en(shift_en), .eval(eval)
  );

  cfgst_judge u_judge (
    .clk(clk), .rst(rst), .test_start(test_start), .eval(eval),
    .last_cell(cfg_q[CFG_BITS-1]), .ff_maj(ff_maj), .fault(fault)
  );

  assign ff_d = cfg_q[CFG_BITS-1];

endmodule

// File: rtl/cfgst_chk.sv
module cfgst_chk #(
  parameter int CFG_BITS = 20
) (
  input logic                clk,
  input logic                rst,
  input logic                test_start,
  input logic                shift_en,
  input logic                ser_in,
  input logic                ff_maj,
  input logic [CFG_BITS-1:0] cfg_q,
  input logic                fault
);

  p_reset_r1: assert property (@(posedge clk) rst |=> (cfg_q == '0) && !fault);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(cfg_q));

  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> cfg_q == {$past(cfg_q[CFG_BITS-2:0]), $past(ser_in)});

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    test_start |=> !fault);

  p_verdict_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> ($past(cfg_q[CFG_BITS-1]) || !$past(ff_maj)));

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    fault && !test_start |=> fault);

endmodule

bind cfg_load_selftest cfgst_chk #(.CFG_BITS(CFG_BITS)) u_chk (
  .clk(clk), .rst(rst), .test_start(test_start), .shift_en(shift_en),
  .ser_in(ser_in), .ff_maj(ff_maj), .cfg_q(cfg_q), .fault(fault)
);

// File: tb/sim_cfg_load_selftest.sv
module sim_cfg_load_selftest;
  localparam int L = 20;
  localparam int N = L + 1;

  logic clk = 0, rst = 1, test_start = 0, shift_en = 0, ser_in = 0;
  logic force_en = 0, force_val = 0, ff_env = 0, ff_d_s = 0, live = 0;
  logic ff_maj, ff_d, fault;
  logic [L-1:0] cfg_q;
  int n_chk = 0, n_fail = 0;

  assign ff_maj = force_en ? force_val : ff_env;

  cfg_load_selftest #(.CFG_BITS(L)) u0 (
    .clk(clk), .rst(rst), .test_start(test_start), .shift_en(shift_en),
    .ser_in(ser_in), .ff_maj(ff_maj), .ff_d(ff_d), .cfg_q(cfg_q), .fault(fault)
  );

  always #4 clk = ~clk;

  // Outside flip-flop triple, collapsed to its majority value.
  always @(negedge clk) ff_d_s = ff_d;
  always @(posedge clk) if (rst) ff_env <= 0; else if (shift_en) ff_env <= ff_d_s;

  // Behavioural reference: queue of chain bits, newest at index 0.
  bit mq[$];
  bit m_fault, m_arm;
  int m_cnt;
  always @(posedge clk) begin
    if (rst) begin
      mq = {};
      for (int i = 0; i < L; i++) mq.push_back(1'b0);
      m_fault = 0; m_arm = 0; m_cnt = 0;
    end else begin
      if (test_start) begin m_arm = 1; m_cnt = 0; m_fault = 0; end
      else if (m_arm) begin
        if (m_cnt == N) begin m_fault = mq[L-1] | ~ff_maj; m_arm = 0; end
        else if (shift_en) m_cnt++;
      end
      if (shift_en) begin mq.push_front(ser_in); void'(mq.pop_back()); end
    end
    live = 1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live) begin
    logic [L-1:0] e;
    for (int i = 0; i < L; i++) e[i] = mq[i];
    check(cfg_q === e, "R2 cfg_q", 64'(cfg_q), 64'(e));
    check(ff_d === e[L-1], "R2 ff_d", 64'(ff_d), 64'(e[L-1]));
    check(fault === m_fault, "R4 fault timing", 64'(fault), 64'(m_fault));
  end

  task automatic step(input logic ts, input logic se, input logic b);
    @(negedge clk); test_start = ts; shift_en = se; ser_in = b;
  endtask

  function automatic logic [N-1:0] good_pat();
    logic [N-1:0] s = '0;
    s[0] = 1; s[N-2] = 1; s[N-1] = 1;
    return s;
  endfunction

  task automatic send(input logic [N-1:0] s, input bit gaps);
    for (int i = 0; i < N; i++) begin
      step(0, 1, s[i]);
      if (gaps && (i % 3 == 1)) step(0, 0, 0);
    end
  endtask

  task automatic expect_fault(input logic e, input string req);
    repeat (3) step(0, 0, 0);
    check(fault === e, req, 64'(fault), 64'(e));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(cfg_q === '0 && ff_d === 0 && fault === 0, "R1 reset", 64'({cfg_q, ff_d, fault}), 64'(0));

    step(1, 0, 0); send(good_pat(), 0); expect_fault(0, "R5 good stream");
    begin
      logic [N-1:0] s = good_pat(); s[0] = 0;
      step(1, 0, 0); send(s, 0); expect_fault(1, "R6 head 00");
    end
    begin
      logic [N-1:0] s = good_pat(); s[1] = 1;
      step(1, 0, 0); send(s, 0); expect_fault(1, "R7 head 11");
    end
    step(1, 0, 0); send('1, 0); expect_fault(1, "R7 all ones");
    send(good_pat(), 0); expect_fault(1, "R9 sticky after more shifts");
    step(1, 0, 0); step(0, 0, 0);
    check(fault === 0, "R3 strobe clears", 64'(fault), 64'(0));

    force_en = 1; force_val = 0;
    step(1, 0, 0); send(good_pat(), 0); expect_fault(1, "R8 flip-flop majority 0");
    force_en = 0;

    step(1, 0, 0); send(good_pat(), 1); expect_fault(0, "R11 gapped good stream");
    begin
      logic [N-1:0] s = good_pat(); s[0] = 0;
      step(1, 0, 0); send(s, 1); expect_fault(1, "R11 gapped bad stream");
    end

    step(1, 0, 0);
    for (int i = 0; i < 7; i++) step(0, 1, 1);
    step(1, 1, 1);
    send(good_pat(), 0); expect_fault(0, "R3 restart mid-stream");

    repeat (2) send('1, 0); expect_fault(0, "R10 no session");

    step(0, 0, 0);
    rst = 1; step(0, 0, 0); step(0, 0, 0); rst = 0;
    check(fault === 0 && cfg_q === '0, "R1 second reset", 64'(fault), 64'(0));

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule